// File: doc/BRIEF.md
# FIFO Service Interrupt Generator

This block raises the service request that tells a host to move a burst of bytes through a 16-entry byte FIFO by programmed I/O, with no DMA. It watches the FIFO occupancy, the transfer direction and a programmed threshold. When the host drains the FIFO (reverse direction), the request asserts once enough bytes are waiting. When the host fills the FIFO (forward direction), the request asserts once enough slots are free. Both trigger levels come from the same threshold value, through opposite formulas.

The request is held off whenever DMA is enabled or the host has set the service mask. The output is registered. It reflects the inputs of the previous clock, so a change of direction or threshold takes effect on the very next cycle. No request from the old direction lingers. The FIFO storage and the host bus decode are outside this block.

Top module: `fifo_svc_irq`

## Requirements
- R1: While rst_n is low, irq is 0.
- R2: When dma_en was 1 at a clock edge, irq is 0 after that edge.
- R3: When svc_mask was 1 at a clock edge, irq is 0 after that edge.
- R4: With dir_rev=1 (FIFO to host), no DMA and no mask, irq becomes 1 exactly when fill_cnt >= 16 - T. T is the effective threshold. For example, T=12 gives irq for counts 4 through 16.
- R5: With dir_rev=0 (host to FIFO), no DMA and no mask, irq becomes 1 exactly when fill_cnt <= T. For example, T=12 gives irq for counts 0 through 12.
- R6: The effective threshold T equals thr when thr is 0..15. Any thr of 16 or more gives T=15.
- R7: irq changes only at a clock edge. It reflects the inputs sampled at that edge, one cycle of latency.
- R8: After dir_rev changes, irq follows the new direction's formula on the first edge that samples the new value. No value from the old direction is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_cnt | input | 5 | FIFO byte count, 0 to 16 |
| dir_rev | input | 1 | 1: FIFO to host, 0: host to FIFO |
| thr | input | 5 | Programmed threshold; 16 and above act as 15 |
| dma_en | input | 1 | DMA enabled; blocks the request |
| svc_mask | input | 1 | Service mask; blocks the request |
| irq | output | 1 | Registered programmed-I/O service request |

## Verification
The bench sweeps every count from 0 to 16 against every threshold from 0 to 17, in both directions and under each gating input. The edge counts matter most. A comparator off by one would lose the full FIFO in the reverse direction at threshold 0, or the empty FIFO in the forward direction at threshold 0. A design that truncated the threshold instead of folding it would treat 16 as 0 and flip most of the table. Each vector is also checked before its clock edge, which catches an unregistered output. A direction flip at fixed count and threshold exposes any request carried over from the old direction.

// File: rtl/fsi_pkg.sv
package fsi_pkg;
  localparam int DEPTH_DEF = 16;

  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } dir_e;
endpackage

// File: rtl/fsi_thr_fold.sv
module fsi_thr_fold #(
  parameter int DEPTH = fsi_pkg::DEPTH_DEF,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input  logic [CNT_W-1:0] thr_raw,
  output logic [THR_W-1:0] thr_eff
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [THR_W-1:0] TOP_C   = THR_W'(DEPTH - 1);

  always_comb begin
    if (thr_raw >= DEPTH_C) thr_eff = TOP_C;
    else                    thr_eff = thr_raw[THR_W-1:0];
  end
endmodule

// File: rtl/fsi_level_cmp.sv
module fsi_level_cmp #(
  parameter int DEPTH = fsi_pkg::DEPTH_DEF,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input  logic [CNT_W-1:0] fill_cnt,
  input  fsi_pkg::dir_e    dir,
  input  logic [THR_W-1:0] thr_eff,
  output logic             hit
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0] thr_w;
  logic [CNT_W-1:0] rev_lvl;
  logic             rev_hit;
  logic             fwd_hit;

  always_comb begin
    thr_w   = CNT_W'(thr_eff);
    rev_lvl = DEPTH_C - thr_w;
    rev_hit = (fill_cnt >= rev_lvl);
    fwd_hit = (fill_cnt <= thr_w);
    hit     = (dir == fsi_pkg::DIR_REV) ? rev_hit : fwd_hit;
  end
endmodule

// File: rtl/fifo_svc_irq.sv
module fifo_svc_irq #(
  parameter int DEPTH = fsi_pkg::DEPTH_DEF,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int THR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fill_cnt,
  input  logic             dir_rev,
  input  logic [CNT_W-1:0] thr,
  input  logic             dma_en,
  input  logic             svc_mask,
  output logic             irq
);
  logic [THR_W-1:0] thr_eff;
  logic             lvl_hit;
  logic             irq_d;
  logic             irq_q;
  logic             irq_en;
  fsi_pkg::dir_e    dir;

  assign dir = fsi_pkg::dir_e'(dir_rev);

  fsi_thr_fold #(.DEPTH(DEPTH)) fold_i (
    .thr_raw (thr),
    .thr_eff (thr_eff)
  );

  fsi_level_cmp #(.DEPTH(DEPTH)) cmp_i (
    .fill_cnt (fill_cnt),
    .dir      (dir),
    .thr_eff  (thr_eff),
    .hit      (lvl_hit)
  );

  // next state
  always_comb begin
    irq_d  = lvl_hit & ~dma_en & ~svc_mask;
    irq_en = irq_d ^ irq_q;
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/fifo_svc_irq_chk.sv
module fifo_svc_irq_chk #(
  parameter int DEPTH = fsi_pkg::DEPTH_DEF,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] fill_cnt,
  input logic             dir_rev,
  input logic [CNT_W-1:0] thr,
  input logic             dma_en,
  input logic             svc_mask,
  input logic             irq
);
  localparam int TOP = DEPTH - 1;

  int t_eff;
  always_comb t_eff = (int'(thr) >= DEPTH) ? TOP : int'(thr);

  p_reset_r1: assert property (@(posedge clk) !rst_n |-> !irq);

  p_dma_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dma_en |=> !irq);

  p_mask_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    svc_mask |=> !irq);

  p_rev_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en && !svc_mask && dir_rev) |=>
      (irq == $past(int'(fill_cnt) >= DEPTH - t_eff)));

  p_fwd_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en && !svc_mask && !dir_rev) |=>
      (irq == $past(int'(fill_cnt) <= t_eff)));

  p_fold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_en && !svc_mask && !dir_rev && int'(thr) >= DEPTH &&
     int'(fill_cnt) == TOP) |=> irq);
endmodule

bind fifo_svc_irq fifo_svc_irq_chk #(.DEPTH(DEPTH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .fill_cnt (fill_cnt),
  .dir_rev  (dir_rev),
  .thr      (thr),
  .dma_en   (dma_en),
  .svc_mask (svc_mask),
  .irq      (irq)
);

// File: tb/fifo_svc_irq_tb_top.sv
`timescale 1ns/1ps
module fifo_svc_irq_tb_top;
  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n;
  logic [CNT_W-1:0] fill_cnt;
  logic             dir_rev;
  logic [CNT_W-1:0] thr;
  logic             dma_en;
  logic             svc_mask;
  logic             irq;

  int checks = 0;
  int fails  = 0;
  logic prev_exp = 1'b0;

  always #5 clk = ~clk;

  fifo_svc_irq #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .fill_cnt(fill_cnt), .dir_rev(dir_rev),
    .thr(thr), .dma_en(dma_en), .svc_mask(svc_mask), .irq(irq)
  );

  function automatic logic model(int c, int t, logic rev, logic d, logic m);
    int te;
    te = (t >= DEPTH) ? DEPTH - 1 : t;
    if (d || m) return 1'b0;
    if (rev) return (c >= DEPTH - te);
    return (c <= te);
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: irq=%0b expected %0b (cnt=%0d thr=%0d rev=%0b dma=%0b mask=%0b)",
               req, act, exp, fill_cnt, thr, dir_rev, dma_en, svc_mask);
    end
  endtask

  // drive at negedge, check old value before the edge, new value after it
  task automatic apply(string req, int c, int t, logic rev, logic d, logic m);
    logic e;
    @(negedge clk);
    fill_cnt = CNT_W'(c); thr = CNT_W'(t); dir_rev = rev;
    dma_en = d; svc_mask = m;
    #1 check("R7", irq, prev_exp);
    e = model(c, t, rev, d, m);
    @(negedge clk);
    check(req, irq, e);
    prev_exp = e;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fill_cnt = '0; dir_rev = 1'b0; thr = '0;
    dma_en = 1'b0; svc_mask = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 state is now released; count 0 forward thr 0 gives a request
    prev_exp = 1'b1;
    check("R5", irq, 1'b1);

    for (int g = 0; g < 3; g++)
      for (int r = 0; r < 2; r++)
        for (int t = 0; t <= DEPTH + 1; t++)
          for (int c = 0; c <= DEPTH; c++) begin
            string req;
            if (g == 1)      req = "R2";
            else if (g == 2) req = "R3";
            else if (t >= DEPTH) req = "R6";
            else if (r == 1) req = "R4";
            else             req = "R5";
            apply(req, c, t, logic'(r), logic'(g == 1), logic'(g == 2));
          end

    // named corner points
    apply("R4", 4, 12, 1'b1, 1'b0, 1'b0);
    apply("R4", 3, 12, 1'b1, 1'b0, 1'b0);
    apply("R5", 12, 12, 1'b0, 1'b0, 1'b0);
    apply("R5", 13, 12, 1'b0, 1'b0, 1'b0);
    apply("R6", 15, 16, 1'b0, 1'b0, 1'b0);
    apply("R6", 1, 16, 1'b1, 1'b0, 1'b0);
    apply("R6", 0, 16, 1'b1, 1'b0, 1'b0);
    // direction flips at fixed count and threshold
    apply("R8", 2, 12, 1'b0, 1'b0, 1'b0);
    apply("R8", 2, 12, 1'b1, 1'b0, 1'b0);
    apply("R8", 2, 12, 1'b0, 1'b0, 1'b0);
    apply("R8", 14, 12, 1'b1, 1'b0, 1'b0);
    apply("R8", 14, 12, 1'b0, 1'b0, 1'b0);

    // reset in mid-request
    apply("R4", 16, 0, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1", irq, 1'b0);
    @(negedge clk);
    check("R1", irq, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule